// File: doc/BRIEF.md
# Thermal Threshold Interrupt Monitor

This block watches an 8-bit temperature code delivered by a sensor front end together with a one-cycle valid strobe. Every valid sample taken while the sensing core is switched on is compared against three rising levels and three falling levels. Each level has a pending bit. A rising bit is set when the code climbs to or past its level. A falling bit is set when the code drops under its level. Software masks the pending bits with an enable word and clears them by writing ones. The block also has a separate hardware-trip level. Once the code reaches that level, with the core and the trip path both enabled, a sticky thermal-trip output goes high. Only reset releases it.

A small word-addressed register bus carries the configuration. Reads are combinational and writes take effect at the clock edge. A 16-bit trim word from the fuse array is captured into a readable register only when software issues a reload command. A sensor-select field in the control word is driven straight out to the analog multiplexer.

Top module: `thermal_irq_mon`

## Requirements
- R1: After reset every register reads zero, and `irq`, `therm_trip` and `sens_sel` are low.
- R2: The register word addresses are: 0 control, 1 rising thresholds, 2 falling thresholds, 3 interrupt enable, 4 pending status (write one to clear), 5 current temperature, 6 trim info and 7 trim control. Control keeps only bits 0, 12 and [23:20]. Enable keeps only bits 0, 4, 8, 16, 20 and 24. Both threshold words keep all 32 bits. Writes to addresses 5 and 6 are ignored.
- R3: Address 5 returns in bits [7:0] the code of the most recent valid sample taken while control bit 0 is set. Its upper bits read zero.
- R4: Rising level k sits in byte k of the rising word, with k = 0 in [7:0], 1 in [15:8] and 2 in [23:16]. Its pending bit 4k sets on a valid sample whose code is at or above the level, when the previous counted sample was below the level or when there has been no counted sample since reset.
- R5: Falling level k sits in byte k of the falling word. Its pending bit 16+4k sets on a valid sample whose code is below the level, when the previous counted sample was not below it or when there has been no counted sample since reset. A level of zero never fires.
- R6: Pending bits set whatever the enable word holds. `irq` is high exactly when some pending bit has its enable bit set.
- R7: Writing a one to a bit of address 4 clears that pending bit on the next edge. If a new event for the same bit arrives in the same cycle, the bit stays set.
- R8: While control bit 0 is clear, samples change no pending bit, no level history and no current temperature.
- R9: `therm_trip` sets on a valid sample when control bits 0 and 12 are both set and the code is at or above rising bits [31:24]. It then stays high until reset.
- R10: Writing address 7 with bit 0 set copies `fuse_trim` into address 6 bits [15:0] (trim byte 1 in [7:0], byte 2 in [15:8]). Changes on `fuse_trim` are not visible in address 6 without a reload.
- R11: `sens_sel` equals control bits [23:20].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| smp_valid | input | 1 | Sample-valid strobe from the sensor interface |
| smp_code | input | 8 | Temperature code of the sample |
| fuse_trim | input | 16 | Trim bytes from the fuse array |
| sens_sel | output | 4 | Sensor multiplexer select |
| irq | output | 1 | Masked interrupt request |
| therm_trip | output | 1 | Sticky hardware thermal trip |

## Verification
Every result is due one edge after its stimulus. A sample or write presented before edge N shows in pending bits, `irq`, `therm_trip`, the current temperature and the trim register after edge N, because `irq` and the read port are combinational on those registers. The bench changes inputs on the falling edge, holds them across exactly one rising edge, and reads the outputs on the following falling edge. The set-versus-clear case presents the clear write and the sample in the same half period, so both meet the same edge.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  localparam int CODE_W  = 8;
  localparam int NLVL    = 3;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int TRIM_W  = 16;
  localparam int MUX_W   = 4;
  localparam int MUX_LSB = 20;
  localparam int TRIP_EN_BIT = 12;
  localparam int STRIDE  = 4;
  localparam int FALL_BASE = 16;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_RISE  = 3'd1,
    RA_FALL  = 3'd2,
    RA_INTEN = 3'd3,
    RA_STAT  = 3'd4,
    RA_TEMP  = 3'd5,
    RA_TRIM  = 3'd6,
    RA_TRIMC = 3'd7
  } reg_addr_e;

  function automatic int rise_bit(input int k);
    return STRIDE * k;
  endfunction

  function automatic int fall_bit(input int k);
    return FALL_BASE + STRIDE * k;
  endfunction

  function automatic logic [DATA_W-1:0] int_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < NLVL; k++) begin
      m[rise_bit(k)] = 1'b1;
      m[fall_bit(k)] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[0] = 1'b1;
    m[TRIP_EN_BIT] = 1'b1;
    for (int i = 0; i < MUX_W; i++) m[MUX_LSB+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [CODE_W-1:0] level_of(input logic [DATA_W-1:0] word,
                                                  input int k);
    return word[k*CODE_W +: CODE_W];
  endfunction
endpackage

// File: rtl/tmon_regfile.sv
module tmon_regfile
  import thermal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] code,
  input  logic [TRIM_W-1:0] fuse,
  input  logic [DATA_W-1:0] pend,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] rise_thr,
  output logic [DATA_W-1:0] fall_thr,
  output logic [DATA_W-1:0] inten,
  output logic [CODE_W-1:0] cur_temp,
  output logic [TRIM_W-1:0] trim,
  output logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] CTRL_M = ctrl_mask();
  localparam logic [DATA_W-1:0] INT_M  = int_mask();

  logic wr_ctrl, wr_rise, wr_fall, wr_en, reload;

  assign wr_ctrl  = wr && (addr == RA_CTRL);
  assign wr_rise  = wr && (addr == RA_RISE);
  assign wr_fall  = wr && (addr == RA_FALL);
  assign wr_en    = wr && (addr == RA_INTEN);
  assign reload   = wr && (addr == RA_TRIMC) && wdata[0];
  assign clr_mask = (wr && (addr == RA_STAT)) ? (wdata & INT_M) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      rise_thr <= '0;
      fall_thr <= '0;
      inten    <= '0;
      cur_temp <= '0;
      trim     <= '0;
    end else begin
      if (wr_ctrl) ctrl     <= wdata & CTRL_M;
      if (wr_rise) rise_thr <= wdata;
      if (wr_fall) fall_thr <= wdata;
      if (wr_en)   inten    <= wdata & INT_M;
      if (reload)  trim     <= fuse;
      if (smp_valid && ctrl[0]) cur_temp <= code;
    end
  end

  always_comb begin
    unique case (addr)
      RA_CTRL:  rdata = ctrl;
      RA_RISE:  rdata = rise_thr;
      RA_FALL:  rdata = fall_thr;
      RA_INTEN: rdata = inten;
      RA_STAT:  rdata = pend;
      RA_TEMP:  rdata = {{(DATA_W-CODE_W){1'b0}}, cur_temp};
      RA_TRIM:  rdata = {{(DATA_W-TRIM_W){1'b0}}, trim};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmon_level_det.sv
module tmon_level_det #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_go,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] rise_lvl,
  input  logic [CODE_W-1:0] fall_lvl,
  output logic              rise_ev,
  output logic              fall_ev
);
  logic at_or_above, below;
  logic hi_q, lo_q;

  assign at_or_above = (code >= rise_lvl);
  assign below       = (fall_lvl != '0) && (code < fall_lvl);

  assign rise_ev = smp_go && at_or_above && !hi_q;
  assign fall_ev = smp_go && below && !lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (smp_go) begin
      hi_q <= at_or_above;
      lo_q <= below;
    end
  end
endmodule

// File: rtl/tmon_pending.sv
module tmon_pending #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [DATA_W-1:0] inten,
  output logic [DATA_W-1:0] pend,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | set_mask;
  end

  assign irq = |(pend & inten);
endmodule

// File: rtl/thermal_irq_mon.sv
module thermal_irq_mon
  import thermal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [TRIM_W-1:0] fuse_trim,
  output logic [MUX_W-1:0]  sens_sel,
  output logic              irq,
  output logic              therm_trip
);
  localparam int TRIP_LSB = NLVL * CODE_W;

  logic [DATA_W-1:0] ctrl, rise_thr, fall_thr, inten, clr_mask, pend, set_mask;
  logic [CODE_W-1:0] cur_temp;
  logic [TRIM_W-1:0] trim;
  logic [NLVL-1:0]   rise_ev, fall_ev;
  logic              core_en, trip_en, smp_go, trip_hit;

  assign core_en  = ctrl[0];
  assign trip_en  = ctrl[TRIP_EN_BIT];
  assign sens_sel = ctrl[MUX_LSB +: MUX_W];
  assign smp_go   = smp_valid && core_en;

  tmon_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .smp_valid(smp_valid), .code(smp_code), .fuse(fuse_trim), .pend(pend),
    .ctrl(ctrl), .rise_thr(rise_thr), .fall_thr(fall_thr), .inten(inten),
    .cur_temp(cur_temp), .trim(trim), .clr_mask(clr_mask), .rdata(bus_rdata)
  );

  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    tmon_level_det #(.CODE_W(CODE_W)) u_det (
      .clk(clk), .rst_n(rst_n), .smp_go(smp_go), .code(smp_code),
      .rise_lvl(level_of(rise_thr, k)), .fall_lvl(level_of(fall_thr, k)),
      .rise_ev(rise_ev[k]), .fall_ev(fall_ev[k])
    );
  end

  always_comb begin
    set_mask = '0;
    for (int k = 0; k < NLVL; k++) begin
      set_mask[rise_bit(k)] = rise_ev[k];
      set_mask[fall_bit(k)] = fall_ev[k];
    end
  end

  tmon_pending #(.DATA_W(DATA_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .inten(inten), .pend(pend), .irq(irq)
  );

  assign trip_hit = smp_go && trip_en && (smp_code >= rise_thr[TRIP_LSB +: CODE_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        therm_trip <= 1'b0;
    else if (trip_hit) therm_trip <= 1'b1;
  end
endmodule

// File: rtl/tmon_chk.sv
module tmon_chk
  import thermal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              core_en,
  input logic              trip_en,
  input logic [DATA_W-1:0] clr_mask,
  input logic [DATA_W-1:0] pend,
  input logic [DATA_W-1:0] inten,
  input logic [CODE_W-1:0] cur_temp,
  input logic              irq,
  input logic              therm_trip
);
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    therm_trip |=> therm_trip); // R9
  AST_TRIP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!therm_trip && !(core_en && trip_en)) |=> !therm_trip); // R9
  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_en && clr_mask == '0) |=> $stable(pend)); // R8
  AST_SET_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ((pend & ~$past(pend)) == '0)); // R4
  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(cur_temp)); // R3
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (inten == '0) |-> !irq); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask[0] && !smp_valid) |=> !pend[0]); // R7
endmodule

bind thermal_irq_mon tmon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .core_en(core_en),
  .trip_en(trip_en), .clr_mask(clr_mask), .pend(pend), .inten(inten),
  .cur_temp(cur_temp), .irq(irq), .therm_trip(therm_trip)
);

// File: tb/thermal_irq_mon_tb.sv
`timescale 1ns/1ps
module thermal_irq_mon_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_code = '0;
  logic [15:0] fuse_trim = '0;
  logic [3:0]  sens_sel;
  logic        irq, therm_trip;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  thermal_irq_mon u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
    .smp_code(smp_code), .fuse_trim(fuse_trim), .sens_sel(sens_sel),
    .irq(irq), .therm_trip(therm_trip)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_wr = 1'b0; smp_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic sample(input logic [7:0] c);
    smp_valid = 1'b1; smp_code = c;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1 reg zero", d, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 trip", {31'b0, therm_trip}, 32'h0);
    chk("R1 sens_sel", {28'b0, sens_sel}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R2 ctrl mask", d, 32'h00F0_1001);
    chk("R11 sens_sel", {28'b0, sens_sel}, 32'hF);
    wr(3'd0, 32'h0050_0000); chk("R11 sens_sel 5", {28'b0, sens_sel}, 32'h5);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R2 inten mask", d, 32'h0111_0111);
    wr(3'd1, 32'hA5C3_3C5A); rd(3'd1, d); chk("R2 rise word", d, 32'hA5C3_3C5A);
    wr(3'd2, 32'h5A3C_C3A5); rd(3'd2, d); chk("R2 fall word", d, 32'h5A3C_C3A5);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, d); chk("R2 temp read-only", d, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, d); chk("R2 trim read-only", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    do_reset();
    wr(3'd1, 32'hFF46_3C32);  // levels 50, 60, 70; trip level 255
    wr(3'd0, 32'h1);
    sample(8'd40); rd(3'd4, d); chk("R4 below", d, 32'h0);
    rd(3'd5, d); chk("R3 temp", d, 32'd40);
    sample(8'd55); rd(3'd4, d); chk("R4 level0", d, 32'h1);
    sample(8'd65); rd(3'd4, d); chk("R4 level1", d, 32'h11);
    wr(3'd4, 32'h111); rd(3'd4, d); chk("R7 clear", d, 32'h0);
    sample(8'd66); rd(3'd4, d); chk("R4 no re-fire above", d, 32'h0);
    sample(8'd40); sample(8'd50); rd(3'd4, d); chk("R4 rearm at level", d, 32'h1);
    sample(8'd75); rd(3'd4, d); chk("R4 level1+2", d, 32'h111);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    do_reset();
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_002D);  // level0 = 45, others zero
    wr(3'd0, 32'h1);
    sample(8'd50); rd(3'd4, d); chk("R5 above", d, 32'h0);
    sample(8'd40); rd(3'd4, d); chk("R5 drop", d, 32'h1_0000);
    wr(3'd4, 32'h1_0000);
    sample(8'd30); rd(3'd4, d); chk("R5 still below no fire", d, 32'h0);
    sample(8'd45); sample(8'd44); rd(3'd4, d); chk("R5 re-fire", d, 32'h1_0000);
    sample(8'd0); rd(3'd4, d); chk("R5 zero levels silent", d, 32'h1_0000);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    wr(3'd1, 32'hFFFF_FF0A);
    wr(3'd0, 32'h1);
    sample(8'd20); rd(3'd4, d); chk("R6 set without enable", d, 32'h1);
    chk("R6 irq masked", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h1); chk("R6 irq enabled", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h1); chk("R6 irq after clear", {31'b0, irq}, 32'h0);
    sample(8'd5);
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h1;
    smp_valid = 1'b1; smp_code = 8'd20;
    @(negedge clk);
    bus_wr = 1'b0; smp_valid = 1'b0;
    rd(3'd4, d); chk("R7 set wins", d, 32'h1);
    wr(3'd4, 32'h1); rd(3'd4, d); chk("R7 clear alone", d, 32'h0);
  endtask

  task automatic t_core_off();
    logic [31:0] d;
    do_reset();
    wr(3'd1, 32'hFFFF_FF0A);
    sample(8'd20); rd(3'd4, d); chk("R8 off no pend", d, 32'h0);
    rd(3'd5, d); chk("R8 off no temp", d, 32'h0);
    wr(3'd0, 32'h1);
    sample(8'd20); rd(3'd4, d); chk("R8 history frozen", d, 32'h1);
    rd(3'd5, d); chk("R3 temp on", d, 32'd20);
  endtask

  task automatic t_trip();
    do_reset();
    wr(3'd1, 32'h64FF_FFFF);
    wr(3'd0, 32'h1);
    sample(8'd120); chk("R9 trip disabled", {31'b0, therm_trip}, 32'h0);
    wr(3'd0, 32'h1001);
    sample(8'd99); chk("R9 below trip", {31'b0, therm_trip}, 32'h0);
    sample(8'd100); chk("R9 trip", {31'b0, therm_trip}, 32'h1);
    sample(8'd20); wr(3'd0, 32'h0);
    chk("R9 sticky", {31'b0, therm_trip}, 32'h1);
  endtask

  task automatic t_trim();
    logic [31:0] d;
    do_reset();
    fuse_trim = 16'h3721;
    rd(3'd6, d); chk("R10 no reload", d, 32'h0);
    wr(3'd7, 32'h1); rd(3'd6, d); chk("R10 reload", d, 32'h3721);
    fuse_trim = 16'h1111;
    @(negedge clk); rd(3'd6, d); chk("R10 fuse change hidden", d, 32'h3721);
    wr(3'd7, 32'h0); rd(3'd6, d); chk("R10 bit0 clear", d, 32'h3721);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_mask();
    t_core_off();
    t_trip();
    t_trim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule